// File: doc/BRIEF.md
# Multilevel Page Table Walker

This block turns a virtual address into a physical address by walking a radix tree of translation tables kept in memory. A lookup starts at a root table and reads one 64-bit entry per level. A 9-bit slice of the virtual address, taken from the highest level down, selects the entry in each table. Each valid non-leaf entry gives the base of the next smaller table. The walk ends at a 4 KB leaf entry, at a 2 MB leaf entry, or at a fault.

The depth is chosen per lookup. With four levels, 48 virtual address bits are translated and the reachable space is 256 TiB. With five levels, 57 bits are translated and the space is 128 PiB. Entries are read through a single-outstanding request/response port that carries wide physical addresses. Only one lookup is in flight at a time. The answer is held until the requester takes it.

Top module: `pgwalk`

## Requirements
- R1: With `req_five` low the walk starts at level 4 and a full 4 KB walk makes exactly 4 entry reads. With `req_five` high it starts at level 5, indexed by VA bits 56:48, and makes exactly 5 reads. Level L is indexed by VA bits [12+9(L-1) +: 9], and level 1 is the lowest.
- R2: Each entry address is the table base bits 51:12, followed by the 9-bit index, followed by three zero bits. The first base is `root_addr` bits 51:12, and the low 12 bits of `root_addr` are ignored.
- R3: The VA is non-canonical when bits 63:47 (four-level) or bits 63:56 (five-level) are not all equal. A non-canonical request answers with `rsp_fault`=1, `rsp_level`=0 and `rsp_pa`=0, and it issues no memory read.
- R4: Bit 0 of an entry is the present flag. When it is clear, the walk stops with `rsp_fault`=2 and `rsp_level` equal to that level, and no further reads are issued.
- R5: A present level-1 entry finishes the walk with `rsp_fault`=0, `rsp_level`=1 and `rsp_pa` = {entry[51:12], VA[11:0]}.
- R6: A present level-2 entry with bit 7 set finishes the walk one read early, with `rsp_fault`=0, `rsp_level`=2 and `rsp_pa` = {entry[51:21], VA[20:0]}.
- R7: Bit 7 has no effect on entries at any level other than 2.
- R8: Entry bits 63:52, bits 11:8 and bits 6:1 do not affect the next table base or the result.
- R9: `req_ready` is high only when no lookup is in progress, and at most one memory read is outstanding at a time.
- R10: Once `rsp_valid` rises, it stays high and `rsp_pa`, `rsp_fault` and `rsp_level` stay unchanged until `rsp_ready` is seen. On any fault `rsp_pa` is 0.
- R11: While `mem_req_valid` is high and not yet accepted, `mem_req_addr` is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 64 | Virtual address to translate |
| req_five | input | 1 | 1: five-level, 0: four-level walk |
| root_addr | input | 52 | Physical address of the root table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Physical address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry contents |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_pa | output | 52 | Translated physical address |
| rsp_fault | output | 2 | 0 none, 1 non-canonical, 2 not present |
| rsp_level | output | 3 | Level where the walk ended (0 for non-canonical) |

## Verification
The bench builds a fresh table tree in a sparse memory model for every lookup. Entry bits outside the base and the flags are filled with random values, so a decoder that slices the base wrongly reads an empty entry and reports a false not-present fault. Directed cases cover addresses that are canonical in one mode but not the other, so a canonical check tied to the wrong mode faults or issues reads where it should not. They also cover a not-present entry at the top level and at the lowest level, which a walker with an off-by-one level counter reports at the wrong level. Further cases cover a 2 MB leaf and a large-page bit at other levels, which a walker that tests the bit at the wrong depth ends early or too late, with a visibly wrong read count and address.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_NONCANON = 2'd1,
    FLT_NOTPRES  = 2'd2
  } flt_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } wstate_e;

endpackage

// File: rtl/pgwalk_canon.sv
module pgwalk_canon #(
  parameter int VA_W    = 64,
  parameter int OFS_W   = 12,
  parameter int IDX_W   = 9,
  parameter int MAX_LVL = 5
) (
  input  logic [VA_W-1:OFS_W+IDX_W*(MAX_LVL-1)-1] va_hi,
  input  logic                                   five,
  output logic                                   ok
);
  localparam int TOP_LO = OFS_W + IDX_W*(MAX_LVL-1) - 1;
  localparam int TOP_HI = OFS_W + IDX_W*MAX_LVL - 1;

  logic ok_lo, ok_hi;

  assign ok_lo = (&va_hi) | ~(|va_hi);
  assign ok_hi = (&va_hi[VA_W-1:TOP_HI]) | ~(|va_hi[VA_W-1:TOP_HI]);
  assign ok    = five ? ok_hi : ok_lo;

  logic lo_unused;
  assign lo_unused = ^va_hi[TOP_LO];
endmodule

// File: rtl/pgwalk_index.sv
module pgwalk_index #(
  parameter int OFS_W   = 12,
  parameter int IDX_W   = 9,
  parameter int MAX_LVL = 5,
  parameter int LVL_W   = 3
) (
  input  logic [OFS_W+IDX_W*MAX_LVL-1:OFS_W] va_idx,
  input  logic [LVL_W-1:0]                   lvl,
  output logic [IDX_W-1:0]                   idx
);
  logic [IDX_W-1:0] slice [MAX_LVL];

  for (genvar g = 0; g < MAX_LVL; g++) begin : g_lvl
    assign slice[g] = va_idx[OFS_W+IDX_W*g +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < MAX_LVL; i++) begin
      if (lvl == LVL_W'(i+1)) idx = slice[i];
    end
  end
endmodule

// File: rtl/pgwalk_pte_dec.sv
module pgwalk_pte_dec #(
  parameter int PTE_W    = 64,
  parameter int PA_W     = 52,
  parameter int OFS_W    = 12,
  parameter int IDX_W    = 9,
  parameter int LVL_W    = 3,
  parameter int LG_BIT   = 7,
  parameter int PRES_BIT = 0
) (
  input  logic [PTE_W-1:0]       pte,
  input  logic [LVL_W-1:0]       lvl,
  input  logic [OFS_W+IDX_W-1:0] va_lo,
  output logic                   present,
  output logic                   leaf,
  output logic [PA_W-OFS_W-1:0]  next_ppn,
  output logic [PA_W-1:0]        leaf_pa
);
  localparam int BIG_W = OFS_W + IDX_W;

  logic big;

  assign present  = pte[PRES_BIT];
  assign big      = (lvl == LVL_W'(2)) && pte[LG_BIT];
  assign leaf     = (lvl == LVL_W'(1)) || big;
  assign next_ppn = pte[PA_W-1:OFS_W];
  assign leaf_pa  = big ? {pte[PA_W-1:BIG_W], va_lo}
                        : {pte[PA_W-1:OFS_W], va_lo[OFS_W-1:0]};

  logic pte_unused;
  assign pte_unused = ^{pte[PTE_W-1:PA_W], pte[OFS_W-1:LG_BIT+1], pte[LG_BIT-1:PRES_BIT+1]};
endmodule

// File: rtl/pgwalk.sv
module pgwalk
  import pgwalk_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int PA_W    = 52,
  parameter int PTE_W   = 64,
  parameter int OFS_W   = 12,
  parameter int IDX_W   = 9,
  parameter int MAX_LVL = 5,
  parameter int LVL_W   = $clog2(MAX_LVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_five,
  input  logic [PA_W-1:0]  root_addr,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_pa,
  output logic [1:0]       rsp_fault,
  output logic [LVL_W-1:0] rsp_level
);
  localparam int XL_W  = OFS_W + IDX_W*MAX_LVL;
  localparam int PPN_W = PA_W - OFS_W;
  localparam int AL_W  = OFS_W - IDX_W;
  localparam int CN_LO = OFS_W + IDX_W*(MAX_LVL-1) - 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  wstate_e          st_q, st_n;
  logic [XL_W-1:0]  va_q, va_n;
  logic [PPN_W-1:0] base_q, base_n;
  logic [LVL_W-1:0] lvl_q, lvl_n;
  logic [PA_W-1:0]  pa_q, pa_n;
  flt_e             flt_q, flt_n;
  logic [LVL_W-1:0] rlvl_q, rlvl_n;
  logic             walk_en, res_en;

  logic             canon_ok, present, leaf;
  logic [IDX_W-1:0] idx;
  logic [PPN_W-1:0] next_ppn;
  logic [PA_W-1:0]  leaf_pa;

  pgwalk_canon #(.VA_W(VA_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .MAX_LVL(MAX_LVL)) u_canon (
    .va_hi (req_va[VA_W-1:CN_LO]),
    .five  (req_five),
    .ok    (canon_ok)
  );

  pgwalk_index #(.OFS_W(OFS_W), .IDX_W(IDX_W), .MAX_LVL(MAX_LVL), .LVL_W(LVL_W)) u_index (
    .va_idx (va_q[XL_W-1:OFS_W]),
    .lvl    (lvl_q),
    .idx    (idx)
  );

  pgwalk_pte_dec #(.PTE_W(PTE_W), .PA_W(PA_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_dec (
    .pte      (mem_rsp_data),
    .lvl      (lvl_q),
    .va_lo    (va_q[OFS_W+IDX_W-1:0]),
    .present  (present),
    .leaf     (leaf),
    .next_ppn (next_ppn),
    .leaf_pa  (leaf_pa)
  );

  always_comb begin
    st_n    = st_q;
    va_n    = va_q;
    base_n  = base_q;
    lvl_n   = lvl_q;
    pa_n    = pa_q;
    flt_n   = flt_q;
    rlvl_n  = rlvl_q;
    walk_en = 1'b0;
    res_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        walk_en = 1'b1;
        va_n    = req_va[XL_W-1:0];
        base_n  = root_addr[PA_W-1:OFS_W];
        lvl_n   = req_five ? LVL_W'(MAX_LVL) : LVL_W'(MAX_LVL-1);
        if (!canon_ok) begin
          res_en = 1'b1;
          st_n   = ST_DONE;
          flt_n  = FLT_NONCANON;
          rlvl_n = '0;
          pa_n   = '0;
        end else begin
          st_n = ST_ISSUE;
        end
      end
      ST_ISSUE: if (mem_req_ready) st_n = ST_WAIT;
      ST_WAIT: if (mem_rsp_valid) begin
        if (!present) begin
          res_en = 1'b1;
          st_n   = ST_DONE;
          flt_n  = FLT_NOTPRES;
          rlvl_n = lvl_q;
          pa_n   = '0;
        end else if (leaf) begin
          res_en = 1'b1;
          st_n   = ST_DONE;
          flt_n  = FLT_NONE;
          rlvl_n = lvl_q;
          pa_n   = leaf_pa;
        end else begin
          walk_en = 1'b1;
          base_n  = next_ppn;
          lvl_n   = lvl_q - LVL_W'(1);
          st_n    = ST_ISSUE;
        end
      end
      ST_DONE: if (rsp_ready) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= ST_IDLE;
      va_q   <= '0;
      base_q <= '0;
      lvl_q  <= '0;
      pa_q   <= '0;
      flt_q  <= FLT_NONE;
      rlvl_q <= '0;
    end else begin
      st_q <= st_n;
      if (walk_en) begin
        va_q   <= va_n;
        base_q <= base_n;
        lvl_q  <= lvl_n;
      end
      if (res_en) begin
        pa_q   <= pa_n;
        flt_q  <= flt_n;
        rlvl_q <= rlvl_n;
      end
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_ISSUE);
  assign mem_req_addr  = {base_q, idx, {AL_W{1'b0}}};
  assign rsp_valid     = (st_q == ST_DONE);
  assign rsp_pa        = pa_q;
  assign rsp_fault     = flt_q;
  assign rsp_level     = rlvl_q;

  logic root_unused;
  assign root_unused = ^root_addr[OFS_W-1:0];
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int PA_W  = 52,
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PA_W-1:0]  rsp_pa,
  input logic [1:0]       rsp_fault,
  input logic [LVL_W-1:0] rsp_level
);
  // R9
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req_valid) |-> !req_ready);

  // R9
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  // R11
  mreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_fault) && $stable(rsp_level)));

  // R10
  fault_pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_pa == '0));

  // R3
  noncanon_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'd1) |-> (rsp_level == '0));

  // R5
  leaf_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'd0) |-> (rsp_level == LVL_W'(1) || rsp_level == LVL_W'(2)));
endmodule

bind pgwalk pgwalk_chk #(.PA_W(PA_W), .LVL_W(LVL_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_pa        (rsp_pa),
  .rsp_fault     (rsp_fault),
  .rsp_level     (rsp_level)
);

// File: tb/sim_pgwalk.sv
`timescale 1ns/1ps
module sim_pgwalk;
  localparam int K_NORM = 0, K_LARGE = 1, K_NP = 2, K_NC = 3;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_five;
  logic [63:0] req_va;
  logic [51:0] root_addr;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [51:0] mem_req_addr;
  logic [63:0] mem_rsp_data;
  logic        rsp_valid, rsp_ready;
  logic [51:0] rsp_pa;
  logic [1:0]  rsp_fault;
  logic [2:0]  rsp_level;

  int checks = 0, errors = 0, reads = 0;
  logic [63:0] tbl [logic [51:0]];

  pgwalk u0 (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // memory model: random accept, 0..2 cycle latency
  initial begin
    logic        pend;
    logic [51:0] paddr, held;
    logic        was_wait;
    int          dly;
    pend = 0; dly = 0; was_wait = 0; held = '0; paddr = '0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (was_wait && mem_req_valid) chk("R11", mem_req_addr, held);
      was_wait = 0;
      if (pend) begin
        mem_req_ready = 0;
        if (dly == 0) begin
          mem_rsp_valid = 1;
          mem_rsp_data  = tbl.exists(paddr) ? tbl[paddr] : 64'h0;
          pend = 0;
        end else dly--;
      end else begin
        mem_req_ready = rst_n && ($urandom % 3 != 0);
        if (mem_req_valid && mem_req_ready) begin
          paddr = mem_req_addr; pend = 1; dly = $urandom % 3; reads++;
        end else if (mem_req_valid) begin
          was_wait = 1; held = mem_req_addr;
        end
      end
    end
  end

  function automatic logic [63:0] canon(input logic [63:0] va, input logic five);
    int t = five ? 56 : 47;
    for (int i = 0; i < 64; i++) if (i > t) va[i] = va[t];
    return va;
  endfunction

  task automatic walk(input logic [63:0] va, input logic five, input int kind,
                      input int stop, input bit force_ps, input string tag);
    int          nlev = five ? 5 : 4;
    logic [39:0] base, nxt, rb;
    logic [63:0] pte;
    logic [51:0] a, e_pa;
    logic [1:0]  e_flt;
    logic [2:0]  e_lvl;
    int          e_reads, hold;
    bit          fin;
    tbl.delete();
    rb = {$urandom, $urandom}; base = rb;
    e_pa = '0; e_flt = 0; e_lvl = 0; e_reads = 0; fin = 0;
    if (kind != K_NC) begin
      for (int l = nlev; l >= 1; l--) begin
        if (!fin) begin
          a   = {base, va[12+9*(l-1) +: 9], 3'b000};
          pte = {$urandom, $urandom};
          nxt = {$urandom, $urandom};
          if (kind == K_NP && l == stop) begin
            tbl[a] = pte & ~64'h1;
            e_flt = 2; e_lvl = 3'(l); e_reads = nlev - l + 1; fin = 1;
          end else begin
            pte[51:12] = nxt; pte[0] = 1'b1;
            if (l == 2) pte[7] = (kind == K_LARGE);
            else if (force_ps) pte[7] = 1'b1;
            tbl[a] = pte;
            if (l == 2 && kind == K_LARGE) begin
              e_pa = {pte[51:21], va[20:0]}; e_lvl = 2; e_reads = nlev - 1; fin = 1;
            end else if (l == 1) begin
              e_pa = {pte[51:12], va[11:0]}; e_lvl = 1; e_reads = nlev; fin = 1;
            end
            base = nxt;
          end
        end
      end
    end else begin
      e_flt = 1;
    end
    reads = 0;
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_va = va; req_five = five; root_addr = {rb, 12'($urandom)};
    @(negedge clk);
    req_valid = 0;
    chk({tag, " R9 busy"}, req_ready, 1'b0);
    while (!rsp_valid) @(negedge clk);
    hold = $urandom % 3;
    repeat (hold) @(negedge clk);
    chk({tag, " fault"}, rsp_fault, e_flt);
    chk({tag, " level"}, rsp_level, e_lvl);
    chk({tag, " pa"}, rsp_pa, e_pa);
    chk({tag, " reads"}, reads, e_reads);
    if (hold != 0) chk("R10 held", rsp_valid, 1'b1);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] va;
    logic        five;
    int          k, t;
    void'($urandom(32'd1234));
    rst_n = 0; req_valid = 0; req_va = '0; req_five = 0; root_addr = '0; rsp_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R9 reset ready", req_ready, 1'b1);
    chk("R10 reset rsp", rsp_valid, 1'b0);
    chk("R9 reset mreq", mem_req_valid, 1'b0);

    walk(64'hFFFF_8123_4567_89AB, 1'b0, K_NORM, 0, 0, "R1 R5 four-level high");
    walk(64'h00AB_CDEF_1234_5678, 1'b1, K_NORM, 0, 0, "R1 R2 five-level");
    walk(64'h00AB_CDEF_1234_5678, 1'b0, K_NC,   0, 0, "R3 four-level noncanon");
    walk(64'h8000_0000_0000_1000, 1'b1, K_NC,   0, 0, "R3 five-level noncanon");
    walk(64'hFF7F_0000_0000_0000, 1'b1, K_NP,   5, 0, "R4 top level");
    walk(64'h0000_1234_5678_9ABC, 1'b0, K_NP,   1, 0, "R4 lowest level");
    walk(64'h0000_7FFF_FFFF_FFFF, 1'b0, K_LARGE, 0, 0, "R6 large four");
    walk(64'h0012_3456_789A_BCDE, 1'b1, K_LARGE, 0, 0, "R6 large five");
    walk(64'h0000_0ABC_DEF0_1234, 1'b0, K_NORM, 0, 1, "R7 R8 ps ignored");

    for (int n = 0; n < 400; n++) begin
      five = $urandom % 2;
      va   = canon({$urandom, $urandom}, five);
      k    = $urandom % 4;
      if (k == K_NC) begin
        t = five ? 57 + ($urandom % 7) : 48 + ($urandom % 16);
        va[t] = ~va[t];
      end
      walk(va, five, k, 1 + ($urandom % (five ? 5 : 4)), $urandom % 2,
           k == K_NC ? "R3 rand" : k == K_NP ? "R4 rand" : k == K_LARGE ? "R6 rand" : "R5 R8 rand");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule